// File: doc/BRIEF.md
# Byte-Lane Static RAM Model

A synthesizable, clock-sampled model of a 16-bit static RAM with a pin-style control interface. On every rising clock edge it samples active-low chip select, write strobe, output gate and one enable per byte lane. The sample sets the operating mode for that cycle. The model writes only the lanes whose enable is low. It drives read data only on lanes that are enabled while output is allowed. The bidirectional bus is split into a data-in vector, a data-out vector and one drive-enable bit per lane, so an enclosing bench or pad ring can build the tristate bus.

The mode is a four-state machine held in the state register. The states are STANDBY (deselected, low power), OFF (selected but output gated off), READ and WRITE. Every transition is taken directly: from any state the machine moves to the state decoded from the current sample.
- Chip select high, or every byte enable high, goes to STANDBY.
- Otherwise write strobe low goes to WRITE.
- Otherwise output gate low goes to READ.
- Otherwise the machine goes to OFF.

Each lane keeps its own write window and a one-entry hold register. The window ends when chip select, the write strobe or that lane's enable goes high. At that edge the last sampled address and byte are committed to the array. The array depth is a parameter, and addresses wrap onto it.

Top module: `sram_model`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `standby` is 1, `dout_en` is 00 and `dout` is 0.
- R2: A sample with `cs_n`=1 or `be_n`=11 gives `standby`=1 and `dout_en`=00 one cycle later. In that sample all other inputs are ignored and no array location changes.
- R3: A sample with `cs_n`=0, `we_n`=1, `oe_n`=0 is a read. One cycle later `dout_en[i]` = NOT `be_n[i]`. Lane 0 is bits 7:0 under `be_n[0]`; lane 1 is bits 15:8 under `be_n[1]`. Each enabled lane shows the stored byte at the sampled address.
- R4: A sample with `cs_n`=0, `we_n`=1, `oe_n`=1 and at least one lane enabled gives `dout_en`=00 and `standby`=0 one cycle later.
- R5: A sample with `cs_n`=0, `we_n`=0 and at least one lane enabled is a write, whatever the value of `oe_n`. One cycle later `dout_en`=00 and `standby`=0.
- R6: A lane whose enable is high during a write keeps its stored byte.
- R7: A lane's write window is open in each sample with `cs_n`=0, `we_n`=0 and that lane's enable low. At the first sample where the window is closed, the byte and address from the window's last sample are stored. A read sampled at that same edge already returns the new byte.
- R8: `dout` keeps its previous value in every lane that is not being read.
- R9: The array index is the address modulo `DEPTH`, and `DEPTH` is a power of two. Addresses that differ only above the index bits reach the same word.
- R10: The lanes have separate windows. When one lane's enable rises in mid-write, that lane commits at that edge, and the other lane keeps writing with the data of the later samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| be_n | input | 2 | Byte enables, active low; bit 1 upper lane, bit 0 lower lane |
| addr | input | 17 | Word address |
| din | input | 16 | Write data from the bus |
| dout | output | 16 | Read data, held when a lane is not driven |
| dout_en | output | 2 | Per-lane bus drive enable |
| standby | output | 1 | Deselected / low-power indication |

## Verification
The assertions assume that every control, address and data input is settled at the sampling edge and never changes on it. They also assume that reset is the only way state is cleared. The array has no reset, so reads are only meaningful at locations written since power-up. The stimulus changes inputs only on the falling edge. It prefills the sixteen low word indices before any random read, and it builds random addresses from those indices plus random bits above the index width. Random reads therefore always return known data and also exercise the wrap.

// File: rtl/sram_pkg.sv
package sram_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        M_STANDBY = 2'd0,
        M_OFF     = 2'd1,
        M_READ    = 2'd2,
        M_WRITE   = 2'd3
    } mode_t;
endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
    import sram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             cs_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] be_n,
    output mode_t            mode
);
    // Deselect wins over everything; a write wins over the output gate.
    always_comb begin
        if (cs_n || (&be_n))
            mode = M_STANDBY;
        else if (!we_n)
            mode = M_WRITE;
        else if (!oe_n)
            mode = M_READ;
        else
            mode = M_OFF;
    end
endmodule

// File: rtl/sram_lane.sv
module sram_lane
    import sram_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win,
    input  logic              rd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] din_b,
    output logic [BYTE_W-1:0] dout_b,
    output logic              en
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic              pend;
    logic [IDX_W-1:0]  haddr;
    logic [BYTE_W-1:0] hdata;
    logic              commit;
    logic [BYTE_W-1:0] rdata;

    assign commit = pend && !win;

    // Array write at the edge that closes this lane's window.
    always_ff @(posedge clk) begin
        if (commit)
            mem[haddr] <= hdata;
    end

    // A read at the closing edge sees the byte being committed.
    always_comb begin
        if (commit && (haddr == idx))
            rdata = hdata;
        else
            rdata = mem[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            haddr <= '0;
            hdata <= '0;
        end else if (win) begin
            pend  <= 1'b1;
            haddr <= idx;
            hdata <= din_b;
        end else if (commit) begin
            pend  <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_b <= '0;
            en     <= 1'b0;
        end else begin
            en <= rd;
            if (rd)
                dout_b <= rdata;
        end
    end

    // R8: a lane not being read holds its data output
    a_r8_hold_dout: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(dout_b));
    // R7: an open window always leaves a pending byte behind
    a_r7_window_pends: assert property (@(posedge clk) disable iff (!rst_n)
        win |=> pend);
    // R7: a closed window with a pending byte empties the hold register
    a_r7_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !win) |=> !pend);
endmodule

// File: rtl/sram_model.sv
module sram_model
    import sram_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [LANES-1:0]  be_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [LANES-1:0]  dout_en,
    output logic              standby
);
    mode_t            mode;
    mode_t            state;
    logic [IDX_W-1:0] idx;

    assign idx = addr[IDX_W-1:0];

    sram_mode_dec #(.LANES(LANES)) u_dec (
        .cs_n (cs_n),
        .we_n (we_n),
        .oe_n (oe_n),
        .be_n (be_n),
        .mode (mode)
    );

    // State register: every transition goes to the decoded mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= M_STANDBY;
        else
            state <= mode;
    end

    // Output process.
    always_comb begin
        unique case (state)
            M_STANDBY: standby = 1'b1;
            M_OFF:     standby = 1'b0;
            M_READ:    standby = 1'b0;
            M_WRITE:   standby = 1'b0;
            default:   standby = 1'b1;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane #(.DEPTH(DEPTH)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .win    ((mode == M_WRITE) && !be_n[g]),
            .rd     ((mode == M_READ) && !be_n[g]),
            .idx    (idx),
            .din_b  (din[g*BYTE_W +: BYTE_W]),
            .dout_b (dout[g*BYTE_W +: BYTE_W]),
            .en     (dout_en[g])
        );
    end

    // R2: deselect gives standby with the bus released
    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || (&be_n)) |=> (standby && (dout_en == '0)));
    // R5: a write never drives the bus, whatever the output gate
    a_r5_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n && !(&be_n)) |=> (!standby && (dout_en == '0)));
    // R4: gated-off output while selected
    a_r4_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && oe_n && !(&be_n)) |=> (!standby && (dout_en == '0)));
    // R3: read drives exactly the enabled lanes
    a_r3_lane_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && !oe_n) |=> (dout_en == ~$past(be_n)));
endmodule

// File: tb/sim_sram_model.sv
`timescale 1ns/1ps
module sim_sram_model;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [1:0]  be_n = 2'b11;
    logic [16:0] addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic [1:0]  dout_en;
    logic        standby;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] sh [DEPTH];
    logic        mpend [2];
    logic [9:0]  maddr [2];
    logic [7:0]  mdata [2];
    logic [15:0] exp_dout;
    logic [1:0]  exp_en;
    logic        exp_stby;

    always #2.5 clk = ~clk;

    sram_model u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .be_n(be_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .standby(standby)
    );

    // 0 standby, 1 gated off, 2 read, 3 write
    function automatic int bmode(logic c, logic w, logic o, logic [1:0] b);
        if (c || (b == 2'b11)) return 0;
        if (!w) return 3;
        if (!o) return 2;
        return 1;
    endfunction

    function automatic string mode_tag(int m);
        case (m)
            0: return "R2";
            1: return "R4";
            2: return "R3";
            default: return "R5";
        endcase
    endfunction

    task automatic model_edge();
        int m = bmode(cs_n, we_n, oe_n, be_n);
        logic [9:0] ix = addr[9:0];
        for (int l = 0; l < 2; l++) begin
            logic w = (m == 3) && !be_n[l];
            if (mpend[l] && !w) sh[maddr[l]][l*8 +: 8] = mdata[l];
        end
        for (int l = 0; l < 2; l++) begin
            logic r = (m == 2) && !be_n[l];
            if (r) exp_dout[l*8 +: 8] = sh[ix][l*8 +: 8];
            exp_en[l] = r;
        end
        for (int l = 0; l < 2; l++) begin
            logic w = (m == 3) && !be_n[l];
            if (w) begin
                mpend[l] = 1'b1; maddr[l] = ix; mdata[l] = din[l*8 +: 8];
            end else begin
                mpend[l] = 1'b0;
            end
        end
        exp_stby = (m == 0);
    endtask

    task automatic check_out(string tag);
        checks++;
        if (dout_en !== exp_en || standby !== exp_stby || dout !== exp_dout) begin
            errors++;
            $display("FAIL %s: dout_en=%b exp %b standby=%b exp %b dout=%h exp %h",
                     tag, dout_en, exp_en, standby, exp_stby, dout, exp_dout);
        end
    endtask

    // Apply pins at the falling edge, sample, check one falling edge later.
    task automatic cyc(logic c, logic w, logic o, logic [1:0] b,
                       logic [16:0] a, logic [15:0] d, string tag);
        cs_n = c; we_n = w; oe_n = o; be_n = b; addr = a; din = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_out(tag);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'h5eed_0042;
        int unsigned r;
        r = $urandom(seed);
        for (int i = 0; i < DEPTH; i++) sh[i] = '0;
        for (int l = 0; l < 2; l++) begin
            mpend[l] = 0; maddr[l] = '0; mdata[l] = '0;
        end
        exp_dout = '0; exp_en = '0; exp_stby = 1'b1;

        // R1: reset state, while in reset and right after release
        repeat (3) @(negedge clk);
        check_out("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1");

        // Prefill indices 0..15 on both lanes
        for (int i = 0; i < 16; i++) begin
            cyc(0, 0, 1, 2'b00, 17'(i), {4'(i), 4'hA, 4'h5, 4'(15 - i)}, "R5");
            cyc(1, 1, 1, 2'b11, 17'(i), 16'h0, "R7");
        end
        for (int i = 0; i < 16; i++)
            cyc(0, 1, 0, 2'b00, 17'(i), 16'h0, "R3");

        // R3: single-lane reads
        cyc(0, 1, 0, 2'b10, 17'd4, 16'h0, "R3");
        cyc(0, 1, 0, 2'b01, 17'd5, 16'h0, "R3");
        // R8: dout held across gated-off and standby cycles
        cyc(0, 1, 1, 2'b00, 17'd6, 16'h0, "R8");
        cyc(1, 1, 0, 2'b00, 17'd6, 16'h0, "R8");
        // R4: output gate high while selected
        cyc(0, 1, 1, 2'b01, 17'd2, 16'h0, "R4");
        // R5: write with oe_n low does not drive
        cyc(0, 0, 0, 2'b00, 17'd8, 16'h5AA5, "R5");
        // R7: read at terminating edge sees the new word
        cyc(0, 1, 0, 2'b00, 17'd8, 16'h0, "R7");
        // R6: lower-only write keeps the upper byte
        cyc(0, 0, 1, 2'b10, 17'd7, 16'h33EE, "R6");
        cyc(1, 1, 1, 2'b11, 17'd7, 16'h0, "R6");
        cyc(0, 1, 0, 2'b00, 17'd7, 16'h0, "R6");
        // R10: upper lane drops mid-write, lower continues with new data
        cyc(0, 0, 1, 2'b00, 17'd5, 16'hA1B2, "R10");
        cyc(0, 0, 1, 2'b10, 17'd5, 16'hC3D4, "R10");
        cyc(1, 1, 1, 2'b11, 17'd5, 16'h0, "R10");
        cyc(0, 1, 0, 2'b00, 17'd5, 16'h0, "R10");
        // R9: alias address above the index width
        cyc(0, 0, 1, 2'b00, 17'h1FC03, 16'h9E3C, "R9");
        cyc(1, 1, 1, 2'b11, 17'h0, 16'h0, "R9");
        cyc(0, 1, 0, 2'b00, 17'd3, 16'h0, "R9");
        // R2: deselected writes are ignored
        cyc(0, 0, 0, 2'b11, 17'd3, 16'hFFFF, "R2");
        cyc(1, 0, 0, 2'b00, 17'd3, 16'hFFFF, "R2");
        cyc(0, 1, 0, 2'b00, 17'd3, 16'h0, "R2");

        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            logic c = ($urandom_range(0, 9) < 2);
            logic w = $urandom_range(0, 1) != 0;
            logic o = $urandom_range(0, 1) != 0;
            logic [1:0] b = 2'($urandom_range(0, 3));
            logic [16:0] a = {7'($urandom), 6'b0, 4'($urandom)};
            logic [15:0] d = 16'($urandom);
            cyc(c, w, o, b, a, d, mode_tag(bmode(c, w, o, b)));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule